// File: doc/BRIEF.md
# BiSS C Sensor Frame Transmitter

This block is the sensor end of a point-to-point BiSS C link that returns one position word per read cycle. It watches the clock line driven by the master and produces the serial data line back to it. The block runs from a local system clock. It brings the master clock through a synchronizer and acts on the edges it detects there.

The first falling master-clock edge of a cycle freezes a frame that a parallel interface supplies: the position value, the number of valid resolution bits and an error flag. From the next rising edge onward the block sends one bit per rising edge, in this order:

- the fixed header (acknowledge, start, control bit);
- the 12-bit data word;
- the two active-low flag bits;
- an inverted 6-bit CRC.

After the frame it holds the line low. Once the master clock has stayed high without an edge for a set number of system cycles, the block releases the line high and waits for the next cycle.

Top module: `bsl_slave_tx`

## Requirements
- R1: After reset and whenever no cycle is in progress, `sdo_o` is 1.
- R2: `pos_i`, `res_i` and `err_i` are captured at the first falling edge of `mclk_i` in a cycle. Changes to them after that edge do not alter the frame being sent.
- R3: On the first three rising `mclk_i` edges after capture, `sdo_o` takes the values 0 (acknowledge), 1 (start) and 0 (control bit), in that order.
- R4: The next 12 rising edges carry the data word with the most significant bit first, so bit 11 is on edge 4 and bit 0 is on edge 15.
- R5: With `res_i` = N, where 1 <= N <= 11, data bits 11 down to N are sent as 0 and bits N-1..0 come from `pos_i`. A value of 0 or above 12 in `res_i` selects the full 12 bits.
- R6: Edge 16 carries the inverse of the captured `err_i`. Edge 17 always carries 1.
- R7: Edges 18 to 23 carry the bitwise inverse of a 6-bit CRC, most significant bit first. The CRC uses the polynomial x^6+x+1 (0x43), starts from zero, and covers the 12 data bits and the two flag bits in the order they are sent.
- R8: From rising edge 24 onward `sdo_o` is 0. It stays 0 until the timeout expires.
- R9: If `mclk_i` is high and no `mclk_i` edge has been seen for `TIMEOUT_CYC` system cycles, `sdo_o` returns to 1 and the block goes idle. This applies at any point in a frame, and the next falling edge starts a new frame.
- R10: While `mclk_i` is held low the timeout never ends the cycle. The frame continues correctly at the next rising edge.
- R11: `sdo_o` changes only in the cycle after a detected rising `mclk_i` edge or after the timeout expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Clock line from the master; it idles high |
| pos_i | input | DATA_W | Position value, right-justified |
| res_i | input | RES_W | Number of valid position bits |
| err_i | input | 1 | Error flag, active high |
| sdo_o | output | 1 | Serial data line to the master |

## Verification
The whole cycle state is held in two places: a frame shift register and a one-bit busy state. A corrupted shift position or a bad CRC therefore shows up on `sdo_o` at the very next rising master edge. Sampling every bit of every frame catches it within one bit period. A timeout counter that fails to restart, or that ignores the level of the clock line, shows either as the line going high too early during a low stall or as the line staying low after the master has stopped. A timeout counter fault becomes visible within about one timeout period.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // header bits in send order: acknowledge, start, control
  localparam int          HDR_W    = 3;
  localparam logic [2:0]  HDR_BITS = 3'b010;
  // flag bits after the data word
  localparam int          FLAG_W   = 2;
endpackage

// File: rtl/bsl_mclk_sync.sv
module bsl_mclk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], mclk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/bsl_frame_build.sv
module bsl_frame_build
  import bsl_pkg::*;
#(
  parameter int          DATA_W   = 12,
  parameter int          RES_W    = 4,
  parameter int          CRC_W    = 6,
  parameter logic [5:0]  CRC_POLY = 6'h03,
  localparam int         PAY_W    = DATA_W + FLAG_W,
  localparam int         FRAME_W  = HDR_W + PAY_W + CRC_W
) (
  input  logic [DATA_W-1:0]  pos_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic               err_i,
  output logic [FRAME_W-1:0] frame_o
);
  int                eff_res;
  logic [DATA_W-1:0] word;
  logic [PAY_W-1:0]  payload;
  logic [CRC_W-1:0]  crc;
  logic              fb;

  always_comb begin
    if (int'(res_i) == 0 || int'(res_i) > DATA_W) eff_res = DATA_W;
    else                                          eff_res = int'(res_i);
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign word[g] = pos_i[g] & (g < eff_res);
  end

  assign payload = {word, ~err_i, 1'b1};

  always_comb begin
    crc = '0;
    fb  = 1'b0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb  = payload[i] ^ crc[CRC_W-1];
      crc = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
    end
  end

  assign frame_o = {HDR_BITS, payload, ~crc};
endmodule

// File: rtl/bsl_timeout.sv
module bsl_timeout #(
  parameter int TIMEOUT_CYC = 40,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic edge_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i || edge_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bsl_slave_tx.sv
module bsl_slave_tx
  import bsl_pkg::*;
#(
  parameter int         DATA_W      = 12,
  parameter int         RES_W       = $clog2(DATA_W + 1),
  parameter int         CRC_W       = 6,
  parameter logic [5:0] CRC_POLY    = 6'h03,
  parameter int         TIMEOUT_CYC = 40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_i,
  input  logic [DATA_W-1:0] pos_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              err_i,
  output logic              sdo_o
);
  localparam int FRAME_W = HDR_W + DATA_W + FLAG_W + CRC_W;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic ma_lvl, ma_rise, ma_fall, to_hit;
  logic [FRAME_W-1:0] frame;

  bsl_mclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .mclk_i(mclk_i),
    .lvl_o(ma_lvl), .rise_o(ma_rise), .fall_o(ma_fall)
  );

  bsl_frame_build #(
    .DATA_W(DATA_W), .RES_W(RES_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_build (
    .pos_i(pos_i), .res_i(res_i), .err_i(err_i), .frame_o(frame)
  );

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sdo_q, sdo_d;
  logic               sh_en, sdo_en;

  bsl_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_to (
    .clk(clk), .rst_n(rst_sync_n), .run_i(state_q == ST_SEND),
    .edge_i(ma_rise | ma_fall), .hit_o(to_hit)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    sdo_d   = sdo_q;
    sh_en   = 1'b0;
    sdo_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sdo_en = 1'b1;
        sdo_d  = 1'b1;
        if (ma_fall) begin
          sh_en   = 1'b1;
          sh_d    = frame;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (ma_rise) begin
          sdo_en = 1'b1;
          sdo_d  = sh_q[FRAME_W-1];
          sh_en  = 1'b1;
          sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
        end else if (to_hit && ma_lvl) begin
          sdo_en  = 1'b1;
          sdo_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      sdo_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (sh_en)  sh_q  <= sh_d;
      if (sdo_en) sdo_q <= sdo_d;
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/bsl_slave_tx_chk.sv
module bsl_slave_tx_chk
  import bsl_pkg::*;
#(
  parameter int FRAME_W = 23
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ma_lvl,
  input logic               ma_rise,
  input logic               ma_fall,
  input logic               to_hit,
  input tx_state_e          state_q,
  input logic [FRAME_W-1:0] sh_q,
  input logic               sdo_o
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> sdo_o);

  // R11
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ma_rise && !(to_hit && ma_lvl)) |=> $stable(sdo_o));

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && !ma_rise) |=> $stable(sh_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !ma_fall) |=> $stable(sh_q));

  // R9
  end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && !ma_rise && to_hit && ma_lvl) |=> (state_q == ST_IDLE && sdo_o));

  // R10
  low_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && !ma_lvl) |=> (state_q == ST_SEND));

  // R9
  hit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |-> !$past(ma_rise || ma_fall));
endmodule

bind bsl_slave_tx bsl_slave_tx_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ma_lvl(ma_lvl), .ma_rise(ma_rise),
  .ma_fall(ma_fall), .to_hit(to_hit), .state_q(state_q), .sh_q(sh_q),
  .sdo_o(sdo_o)
);

// File: tb/bsl_slave_tx_test.sv
module bsl_slave_tx_test;
  localparam int TO = 40;
  localparam int H  = 6;

  logic        clk, rst_n, mclk_i, err_i, sdo_o;
  logic [11:0] pos_i;
  logic [3:0]  res_i;
  int          vectors = 0;
  int          fails   = 0;
  bit          done    = 0;

  bsl_slave_tx uut (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .pos_i(pos_i),
    .res_i(res_i), .err_i(err_i), .sdo_o(sdo_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sdo actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] expect_frame(input logic [11:0] pos,
                                               input int res, input logic err);
    int          eff;
    logic [11:0] word;
    logic [19:0] val;
    eff  = (res == 0 || res > 12) ? 12 : res;
    word = pos & 12'((1 << eff) - 1);
    val  = {word, ~err, 1'b1, 6'b0};
    for (int i = 19; i >= 6; i--)
      if (val[i]) val[i -: 7] = val[i -: 7] ^ 7'h43;
    return {3'b010, word, ~err, 1'b1, ~val[5:0]};
  endfunction

  function automatic string tag_of(input int k);
    if (k < 3)  return "R3";
    if (k < 15) return "R4/R5";
    if (k < 17) return "R6";
    if (k < 23) return "R7";
    return "R8";
  endfunction

  // one complete cycle; inputs change after capture to probe R2
  task automatic run_frame(input logic [11:0] pos, input logic [11:0] pos_late,
                           input int res, input logic err, input int stall_at);
    logic [22:0] exp;
    pos_i = pos; res_i = 4'(res); err_i = err;
    cyc(2);
    exp = expect_frame(pos, res, err);
    for (int k = 0; k < 24; k++) begin
      mclk_i = 1'b0;
      cyc((k == stall_at) ? 3 * TO : H);
      if (k == 0) begin
        pos_i = pos_late; err_i = ~err; res_i = 4'd1;  // R2
      end
      mclk_i = 1'b1;
      cyc(H);
      check((k == stall_at) ? "R10" : tag_of(k), sdo_o, (k < 23) ? exp[22-k] : 1'b0);
    end
    cyc(TO - 12);
    check("R8", sdo_o, 1'b0);
    cyc(20);
    check("R9", sdo_o, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mclk_i = 1'b1; pos_i = '0; res_i = '0; err_i = 1'b0;
    cyc(3);
    check("R1", sdo_o, 1'b1);
    rst_n = 1'b1;
    cyc(6);
    check("R1", sdo_o, 1'b1);
    res_i = 4'd5; pos_i = 12'hFFF;
    cyc(4);
    check("R1", sdo_o, 1'b1);
  endtask

  task automatic t_full_res;
    run_frame(12'hA5C, 12'hA5C, 12, 1'b0, -1);   // R4 R6 R7
    run_frame(12'h000, 12'h000, 0, 1'b1, -1);    // R6 error path, R5 zero code
    run_frame(12'hFFF, 12'hFFF, 15, 1'b0, -1);   // R5 out-of-range code
  endtask

  task automatic t_low_res;
    run_frame(12'hFFF, 12'hFFF, 7, 1'b0, -1);    // R5
    run_frame(12'h9B3, 12'h9B3, 1, 1'b1, -1);    // R5
  endtask

  task automatic t_capture;
    run_frame(12'h3C1, 12'hC3E, 12, 1'b1, -1);   // R2
  endtask

  task automatic t_stall;
    run_frame(12'h5A5, 12'h5A5, 12, 1'b0, 9);    // R10
  endtask

  task automatic t_abort;
    pos_i = 12'h123; res_i = 4'd12; err_i = 1'b0;
    cyc(2);
    for (int k = 0; k < 5; k++) begin
      mclk_i = 1'b0; cyc(H); mclk_i = 1'b1; cyc(H);
    end
    cyc(TO + 10);
    check("R9", sdo_o, 1'b1);
    run_frame(12'h456, 12'h456, 12, 1'b0, -1);   // R9 re-arm
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    t_reset();
    t_full_res();
    t_low_res();
    t_capture();
    t_stall();
    t_abort();
    finish_run();
  end
endmodule